// File: doc/BRIEF.md
# DMA Request-Line to Channel Mapper

This block sits between a bank of peripheral request lines and the channels of a DMA engine. Each request line owns a small map entry that either leaves the line unconnected or points it at one channel. Software programs the entries through a simple word-addressed register port. The block samples every request line on each clock. When a mapped line changes, the block updates the request level of its channel and raises the status events that a channel status unit needs.

Two events are produced per channel. The first is a request-after-stop flag. It is set when a request appears on a channel that had none, and it is dropped by any other change on that channel. The second is an end-of-receive pulse. It lasts one clock and fires when a channel's request goes away while the channel was active. Software can write an entry that names a channel the instance does not have. Such a write is refused and recorded in a sticky error bit.

The map entries sit in two word-aligned windows. The lower window holds the first 64 request lines. The upper window holds the remaining ones.

Top module: `rdma_req_mapper`

## Requirements
- R1: After reset every map entry reads 0, and all channel outputs and the error bit are 0.
- R2: A map entry holds a valid flag in bit 7 and a channel number in bits 4:0. The other bits of a written word are dropped, and they read back as 0.
- R3: The entry of request r, for r from 0 to 63, is at byte address 0x100 + 4*r.
- R4: The entry of request r, for r from 64 to NUM_REQ-1, is at byte address 0x1100 + 4*(r-64). An aligned address past the last entry stores nothing and reads 0.
- R5: A request line whose entry has the valid flag clear has no effect on any channel output.
- R6: chan_req_o[c] takes the new level of a mapped line that changed, one clock edge after the change is presented. It holds its value while no mapped line of that channel changes.
- R7: ras_flag_o[c] is set when a mapped line rises while chan_req_o[c] is 0. Any other mapped change on channel c clears it.
- R8: eor_pulse_o[c] is high for exactly one clock when a mapped line falls while chan_req_o[c] is 1.
- R9: When several lines mapped to one channel change on the same clock, the line with the highest request index decides the new level.
- R10: Writing an entry with bit 7 set and a channel number of NUM_CH or more leaves the entry unchanged and sets map_err_o. map_err_o stays set until reset. An entry with bit 7 clear is stored whatever its channel number.
- R11: Byte addresses 0xE0, 0xE4 and 0xE8 read 0, and writes to them change no map entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| req_in | input | NUM_REQ | Peripheral request lines, synchronous to clk |
| chan_req_o | output | NUM_CH | Per-channel request level |
| ras_flag_o | output | NUM_CH | Per-channel request-after-stop flag |
| eor_pulse_o | output | NUM_CH | Per-channel end-of-receive pulse |
| map_err_o | output | 1 | Sticky error for an out-of-range channel |

## Verification
The assertions assume four things about the inputs. The request lines and bus signals are synchronous to clk. They change only between rising edges. Reset is held for at least one edge, so every past value an assertion uses comes from a reset or later cycle. Because of this, an edge on the request lines is measured against the single sample register. The bench keeps to these assumptions: it changes req_in and the bus only on falling edges, and it holds reset for three cycles. It also drives one request line at a time, except in the deliberate same-clock collision that tests the priority rule.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    // Map entry field layout
    localparam int MAP_CH_W    = 5;
    localparam int MAP_VLD_BIT = 7;

    // Register windows (byte addresses)
    localparam int WIN_LO_BASE  = 'h0100;
    localparam int WIN_HI_BASE  = 'h1100;
    localparam int WIN_LO_SLOTS = 64;
    localparam int STAT_ADDR0   = 'h00E0;
    localparam int STAT_ADDR1   = 'h00E4;
    localparam int STAT_ADDR2   = 'h00E8;
endpackage

// File: rtl/rdma_map_regs.sv
module rdma_map_regs
    import rdma_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16,
    parameter int AW      = 16,
    parameter int DW      = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      addr,
    input  logic [DW-1:0]                      wdata,
    output logic [DW-1:0]                      rdata,
    output logic [NUM_REQ-1:0]                 map_vld,
    output logic [NUM_REQ-1:0][MAP_CH_W-1:0]   map_ch,
    output logic                               map_err
);
    localparam int IDX_W   = $clog2(NUM_REQ);
    localparam int LO_CNT  = (NUM_REQ < WIN_LO_SLOTS) ? NUM_REQ : WIN_LO_SLOTS;
    localparam int HI_CNT  = NUM_REQ - LO_CNT;
    localparam logic [AW-1:0] LO_BASE = AW'(WIN_LO_BASE);
    localparam logic [AW-1:0] LO_END  = AW'(WIN_LO_BASE + 4 * LO_CNT);
    localparam logic [AW-1:0] HI_BASE = AW'(WIN_HI_BASE);
    localparam logic [AW-1:0] HI_END  = AW'(WIN_HI_BASE + 4 * HI_CNT);
    localparam logic [MAP_CH_W:0] CH_LIM = (MAP_CH_W + 1)'(NUM_CH);

    typedef struct packed {
        logic [NUM_REQ-1:0]               vld;
        logic [NUM_REQ-1:0][MAP_CH_W-1:0] ch;
        logic                             err;
    } map_st_t;

    map_st_t st_d, st_q;

    logic [AW-1:0]    off_lo, off_hi;
    logic             in_lo, in_hi, hit, aligned, bad_wr, stat_hit;
    logic [IDX_W-1:0] idx;

    // Address decode
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        off_lo   = addr - LO_BASE;
        off_hi   = addr - HI_BASE;
        in_lo    = aligned && (addr >= LO_BASE) && (addr < LO_END);
        in_hi    = aligned && (addr >= HI_BASE) && (addr < HI_END);
        hit      = in_lo || in_hi;
        idx      = in_hi ? (IDX_W'(LO_CNT) + off_hi[IDX_W+1:2]) : off_lo[IDX_W+1:2];
        stat_hit = (addr == AW'(STAT_ADDR0)) || (addr == AW'(STAT_ADDR1)) ||
                   (addr == AW'(STAT_ADDR2));
        bad_wr   = wr_en && hit && wdata[MAP_VLD_BIT] &&
                   ({1'b0, wdata[MAP_CH_W-1:0]} >= CH_LIM);
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (bad_wr) begin
            st_d.err = 1'b1;
        end else if (wr_en && hit) begin
            st_d.vld[idx] = wdata[MAP_VLD_BIT];
            st_d.ch[idx]  = wdata[MAP_CH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read path
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[MAP_VLD_BIT]    = st_q.vld[idx];
            rdata[MAP_CH_W-1:0]   = st_q.ch[idx];
        end
    end

    assign map_vld = st_q.vld;
    assign map_ch  = st_q.ch;
    assign map_err = st_q.err;

    // R10: error bit never drops outside reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R10: refused write raises the error and leaves every entry untouched
    a_r10_bad_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> (st_q.err && $stable(st_q.vld) && $stable(st_q.ch)));

    // R11: status addresses always read zero
    a_r11_stat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_hit |-> (rdata == '0));
endmodule

// File: rtl/rdma_chan_route.sv
module rdma_chan_route
    import rdma_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic [NUM_REQ-1:0]               map_vld,
    input  logic [NUM_REQ-1:0][MAP_CH_W-1:0] map_ch,
    input  logic [NUM_REQ-1:0]               req_now,
    input  logic [NUM_REQ-1:0]               req_prev,
    output logic [NUM_CH-1:0]                chg,
    output logic [NUM_CH-1:0]                lvl
);
    logic [NUM_REQ-1:0] moved;
    assign moved = (req_now ^ req_prev) & map_vld;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [MAP_CH_W-1:0] CID = MAP_CH_W'(c);
        // Ascending scan: the highest changed index is applied last and wins
        always_comb begin
            chg[c] = 1'b0;
            lvl[c] = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (moved[r] && (map_ch[r] == CID)) begin
                    chg[c] = 1'b1;
                    lvl[c] = req_now[r];
                end
            end
        end
    end
endmodule

// File: rtl/rdma_req_mapper.sv
module rdma_req_mapper
    import rdma_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [15:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0]  chan_req_o,
    output logic [NUM_CH-1:0]  ras_flag_o,
    output logic [NUM_CH-1:0]  eor_pulse_o,
    output logic               map_err_o
);
    typedef struct packed {
        logic [NUM_REQ-1:0] smp;
        logic [NUM_CH-1:0]  chan;
        logic [NUM_CH-1:0]  ras;
        logic [NUM_CH-1:0]  eor;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_REQ-1:0]               map_vld;
    logic [NUM_REQ-1:0][MAP_CH_W-1:0] map_ch;
    logic [NUM_CH-1:0]                chg, lvl;

    rdma_map_regs #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH),
        .AW      (16),
        .DW      (32)
    ) i_map_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .map_vld (map_vld),
        .map_ch  (map_ch),
        .map_err (map_err_o)
    );

    rdma_chan_route #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) i_route (
        .map_vld  (map_vld),
        .map_ch   (map_ch),
        .req_now  (req_in),
        .req_prev (st_q.smp),
        .chg      (chg),
        .lvl      (lvl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.smp = req_in;
        st_d.eor = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (chg[c]) begin
                st_d.chan[c] = lvl[c];
                st_d.ras[c]  = lvl[c] && !st_q.chan[c];
                st_d.eor[c]  = !lvl[c] && st_q.chan[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_req_o  = st_q.chan;
    assign ras_flag_o  = st_q.ras;
    assign eor_pulse_o = st_q.eor;

    // R6: without any input movement the channel levels hold
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in == st_q.smp) |=> $stable(st_q.chan));

    // R7: a new request-after-stop flag only appears with a channel turning on
    a_r7_ras_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ras & ~$past(st_q.ras)) & ~(st_q.chan & ~$past(st_q.chan))) == '0);

    // R8: end-of-receive only where the channel just turned off
    a_r8_eor_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.eor) |-> ((st_q.eor & $past(st_q.chan) & ~st_q.chan) == st_q.eor));

    // R8: the pulse never lasts two cycles without a fresh rise in between
    a_r8_eor_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.eor) |=> ((st_q.eor & $past(st_q.eor)) == '0));
endmodule

// File: tb/test_rdma_req_mapper.sv
module test_rdma_req_mapper;
    localparam int NREQ = 75;
    localparam int NCH  = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bus_wr;
    logic [15:0]      bus_addr;
    logic [31:0]      bus_wdata;
    logic [31:0]      bus_rdata;
    logic [NREQ-1:0]  req_in;
    logic [NCH-1:0]   chan_req_o, ras_flag_o, eor_pulse_o;
    logic             map_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rdma_req_mapper #(.NUM_REQ(NREQ), .NUM_CH(NCH)) i_rdma_req_mapper (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .req_in      (req_in),
        .chan_req_o  (chan_req_o),
        .ras_flag_o  (ras_flag_o),
        .eor_pulse_o (eor_pulse_o),
        .map_err_o   (map_err_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] addr_of(input int r);
        if (r < 64) return 16'(16'h0100 + 4 * r);
        return 16'(16'h1100 + 4 * (r - 64));
    endfunction

    function automatic logic [31:0] onehot(input int c);
        return 32'(1) << c;
    endfunction

    task automatic bwrite(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive(input logic [NREQ-1:0] v);
        req_in = v;
        @(negedge clk);
    endtask

    task automatic chk_out(input string tag, input logic [31:0] ec, input logic [31:0] er,
                           input logic [31:0] ee);
        chk({tag, " chan"}, 32'(chan_req_o), ec);
        chk({tag, " ras"},  32'(ras_flag_o), er);
        chk({tag, " eor"},  32'(eor_pulse_o), ee);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [NREQ-1:0] v;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; req_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_out("R1 reset", 0, 0, 0);
        chk("R1 err reset", 32'(map_err_o), 0);
        for (int r = 0; r < NREQ; r++) begin
            bread(addr_of(r), rd);
            chk($sformatf("R1 entry %0d", r), rd, 0);
        end

        // R5: unmapped lines do nothing
        drive('1);
        chk_out("R5 unmapped rise", 0, 0, 0);
        drive('0);
        chk_out("R5 unmapped fall", 0, 0, 0);

        // R2 R3 R4: program every entry with junk in the unused bits
        for (int r = 0; r < NREQ; r++)
            bwrite(addr_of(r), 32'hABCD_EF60 | 32'h80 | 32'(r % NCH));
        for (int r = 0; r < NREQ; r++) begin
            bread(addr_of(r), rd);
            chk($sformatf("R2 R3 R4 entry %0d", r), rd, 32'h80 | 32'(r % NCH));
        end
        // R4: aligned address past the upper window
        bwrite(16'(16'h1100 + 4 * (NREQ - 64)), 32'h0000_0081);
        bread(16'(16'h1100 + 4 * (NREQ - 64)), rd);
        chk("R4 past end reads 0", rd, 0);
        chk("R4 past end no err", 32'(map_err_o), 0);
        bread(addr_of(NREQ - 1), rd);
        chk("R4 last entry intact", rd, 32'h80 | 32'((NREQ - 1) % NCH));

        // R6 R7 R8: each line alone, rise then fall
        @(negedge clk);
        for (int r = 0; r < NREQ; r++) begin
            v = '0; v[r] = 1'b1;
            drive(v);
            chk_out($sformatf("R6 R7 rise req %0d", r), onehot(r % NCH), onehot(r % NCH), 0);
            drive('0);
            chk_out($sformatf("R6 R7 R8 fall req %0d", r), 0, 0, onehot(r % NCH));
            @(negedge clk);
            chk($sformatf("R8 pulse ends req %0d", r), 32'(eor_pulse_o), 0);
        end

        // R7 R9: two lines on channel 3 (requests 3 and 19)
        v = '0; v[3] = 1'b1;
        drive(v);
        chk_out("R7 first rise", onehot(3), onehot(3), 0);
        v[19] = 1'b1;
        drive(v);
        chk_out("R7 rise while active clears", onehot(3), 0, 0);
        v[3] = 1'b0;
        drive(v);
        chk_out("R8 latest change falls", 0, 0, onehot(3));
        v[3] = 1'b1; v[19] = 1'b0;
        drive(v);
        chk_out("R9 highest index wins", 0, 0, 0);
        drive('0);
        chk_out("R9 cleanup", 0, 0, 0);

        // R11: status addresses
        bwrite(16'h00E0, 32'hFFFF_FFFF);
        bwrite(16'h00E4, 32'hFFFF_FFFF);
        bwrite(16'h00E8, 32'hFFFF_FFFF);
        bread(16'h00E0, rd); chk("R11 stat0", rd, 0);
        bread(16'h00E4, rd); chk("R11 stat1", rd, 0);
        bread(16'h00E8, rd); chk("R11 stat2", rd, 0);
        bread(addr_of(0), rd); chk("R11 entry 0 unchanged", rd, 32'h80);

        // R10: range errors
        bwrite(addr_of(5), 32'h0000_0014);
        bread(addr_of(5), rd); chk("R10 invalid entry stored", rd, 32'h14);
        chk("R10 no err for invalid", 32'(map_err_o), 0);
        bwrite(addr_of(6), 32'h0000_0080 | 32'(NCH));
        bread(addr_of(6), rd); chk("R10 boundary refused", rd, 32'h80 | 32'(6 % NCH));
        chk("R10 err set", 32'(map_err_o), 1);
        bwrite(addr_of(5), 32'h0000_0094);
        bread(addr_of(5), rd); chk("R10 over range refused", rd, 32'h14);
        bwrite(addr_of(5), 32'h0000_0085);
        bread(addr_of(5), rd); chk("R10 good write after err", rd, 32'h85);
        chk("R10 err sticky", 32'(map_err_o), 1);
        // R5: entry 5 cleared again makes line 5 inert
        bwrite(addr_of(5), 32'h0000_0005);
        v = '0; v[5] = 1'b1;
        drive(v);
        chk_out("R5 cleared entry", 0, 0, 0);
        drive('0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule